// File: doc/BRIEF.md
# Stream-to-Memory Transfer Control Registers

This block is the software-visible control face of an engine that copies an incoming data stream into memory. It decodes a 64-byte window on a simple register bus with separate read and write strobes. Inside that window it holds four registers: the destination address, the transfer length in bytes, a busy flag and a finished flag. The address and length are handed to the engine. During a transfer the engine can write back its advancing address and its remaining length. The engine reports the end of a transfer with a one-cycle pulse.

Software programs the address and the length, then writes 1 to the busy flag. The start is refused unless both values are multiples of the data-bus byte width. When the engine ends the transfer, the block drops the busy flag and raises the finished flag in the same cycle. The finished flag also drives a level interrupt, which stays high until software writes 0 to that flag.

Top module: `dma_ctrl_regs`

## Requirements
- R1: The block responds only when address bits above bit 5 equal those of the base address (default 0x10017000). Any other address gives no read response and changes no state.
- R2: The register at offset 0x00 holds the destination address, is written and read at its full width, and is driven on `eng_dst_addr`.
- R3: The register at offset 0x08 holds the length in bytes, is written and read at its full width, and is driven on `eng_len`.
- R4: Writing a word with bit 0 = 1 to offset 0x10 while idle sets the busy flag, provided the start is aligned. The busy flag reads back in bit 0 of offset 0x10 and is driven on `eng_busy`. A write of 0 to that offset has no effect.
- R5: A start request is ignored, and the busy flag stays 0, when the address or the length has a nonzero value in its low log2(BEAT_BYTES) bits (bits 2:0 by default).
- R6: An `eng_done` pulse while busy clears the busy flag and sets the finished flag (bit 0 of offset 0x18) on the same clock edge. An `eng_done` pulse while idle is ignored.
- R7: Writing a word with bit 0 = 0 to offset 0x18 clears the finished flag, and writing 1 has no effect. When an end pulse and a clearing write arrive in the same cycle, the flag is set.
- R8: `irq` is high exactly when the finished flag is set.
- R9: While busy, an engine update of the address or the length wins over a bus write to the same register in the same cycle. While idle, engine updates are ignored.
- R10: A read that hits the window gives `bus_rvalid` one cycle later, with the register value zero-extended to 64 bits as it stood before that edge. Unused offsets read as 0, and writes to them are ignored.
- R11: After reset, all four registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after the read |
| bus_rdata | output | 64 | Read response data |
| eng_dst_addr | output | ADDR_W | Destination address to the engine |
| eng_len | output | ADDR_W | Remaining length to the engine |
| eng_busy | output | 1 | Transfer in progress |
| eng_addr_upd | input | 1 | Engine address update strobe |
| eng_addr_val | input | ADDR_W | Engine address update value |
| eng_len_upd | input | 1 | Engine length update strobe |
| eng_len_val | input | ADDR_W | Engine length update value |
| eng_done | input | 1 | End-of-transfer pulse |
| irq | output | 1 | Level interrupt, mirrors the finished flag |

## Verification
Directed sequences first try the corners one at a time. These are an out-of-window write and read, unused-offset writes, a misaligned start, a bus write colliding with an engine update, an end pulse with and without a transfer running, and an end pulse colliding with a clearing write. Each one separates a correct priority or refusal from the plausible wrong one. A long random mix follows, with a fixed seed. It mixes reads and writes at all offsets and outside the window, mostly aligned but sometimes misaligned values, random engine updates and end pulses. Every cycle's read data, interrupt and busy output are compared against a bench model built from the requirements. This catches interactions between the starting, finishing and updating paths that the directed cases do not combine.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    localparam int BUS_W    = 64;
    localparam int WIN_BITS = 6;

    localparam logic [WIN_BITS-1:0] OFF_DST  = 6'h00;
    localparam logic [WIN_BITS-1:0] OFF_LEN  = 6'h08;
    localparam logic [WIN_BITS-1:0] OFF_RUN  = 6'h10;
    localparam logic [WIN_BITS-1:0] OFF_DONE = 6'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DST,
        SEL_LEN,
        SEL_RUN,
        SEL_DONE
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } dec_t;

    // True when the low 'lsb' bits of v are all zero.
    function automatic logic low_clear(input logic [BUS_W-1:0] v, input int unsigned lsb);
        logic [BUS_W-1:0] mask;
        mask = (lsb == 0) ? '0 : ((BUS_W'(1) << lsb) - BUS_W'(1));
        return (v & mask) == '0;
    endfunction

endpackage

// File: rtl/dmar_decode.sv
module dmar_decode
    import dmar_pkg::*;
#(
    parameter int              ADDR_W    = 64,
    parameter logic [63:0]     BASE_ADDR = 64'h1001_7000
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [WIN_BITS-1:0] off;

    always_comb begin
        off     = addr[WIN_BITS-1:0];
        dec.hit = (addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
        unique case (off)
            OFF_DST:  dec.sel = SEL_DST;
            OFF_LEN:  dec.sel = SEL_LEN;
            OFF_RUN:  dec.sel = SEL_RUN;
            OFF_DONE: dec.sel = SEL_DONE;
            default:  dec.sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/dmar_word_reg.sv
module dmar_word_reg #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_val,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_val,
    output logic [ADDR_W-1:0] q
);
    logic eng_take;
    assign eng_take = busy && upd_en;

    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (eng_take) q <= upd_val;
        else if (bus_we)   q <= bus_val;
    end

    AST_ENG_WINS: assert property (@(posedge clk) disable iff (rst)
        (busy && upd_en) |=> (q == $past(upd_val))); // R9

    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && !(busy && upd_en)) |=> $stable(q)); // R2
endmodule

// File: rtl/dmar_flags.sv
module dmar_flags (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic start_ok,
    input  logic clr_req,
    input  logic eng_done,
    output logic running,
    output logic done
);
    logic finish;
    assign finish = running && eng_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            if (finish)                                running <= 1'b0;
            else if (!running && start_req && start_ok) running <= 1'b1;

            if (finish)       done <= 1'b1;
            else if (clr_req) done <= 1'b0;
        end
    end

    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        (running && eng_done) |=> (done && !running)); // R6

    AST_RUN_FALLS_ON_END: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> $past(eng_done)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !clr_req) |=> done); // R7
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dmar_pkg::*;
#(
    parameter int          ADDR_W     = 64,
    parameter int          BEAT_BYTES = 8,
    parameter logic [63:0] BASE_ADDR  = 64'h1001_7000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [63:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [63:0]       bus_rdata,
    output logic [ADDR_W-1:0] eng_dst_addr,
    output logic [ADDR_W-1:0] eng_len,
    output logic              eng_busy,
    input  logic              eng_addr_upd,
    input  logic [ADDR_W-1:0] eng_addr_val,
    input  logic              eng_len_upd,
    input  logic [ADDR_W-1:0] eng_len_val,
    input  logic              eng_done,
    output logic              irq
);
    localparam int unsigned ALIGN_LSB = $clog2(BEAT_BYTES);
    localparam int          N_WORDS   = 2;

    dec_t dec;
    logic running, done_q, aligned;
    logic start_req, clr_req, rd_hit;
    logic [ADDR_W-1:0] word_q   [N_WORDS];
    logic              word_we  [N_WORDS];
    logic              word_upd [N_WORDS];
    logic [ADDR_W-1:0] word_uv  [N_WORDS];
    logic [63:0]       rd_mux;

    dmar_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign word_we[0]  = bus_wr && dec.hit && (dec.sel == SEL_DST);
    assign word_we[1]  = bus_wr && dec.hit && (dec.sel == SEL_LEN);
    assign word_upd[0] = eng_addr_upd;
    assign word_upd[1] = eng_len_upd;
    assign word_uv[0]  = eng_addr_val;
    assign word_uv[1]  = eng_len_val;

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        dmar_word_reg #(.ADDR_W(ADDR_W)) u_word (
            .clk     (clk),
            .rst     (rst),
            .busy    (running),
            .bus_we  (word_we[i]),
            .bus_val (bus_wdata[ADDR_W-1:0]),
            .upd_en  (word_upd[i]),
            .upd_val (word_uv[i]),
            .q       (word_q[i])
        );
    end

    assign aligned   = low_clear(BUS_W'(word_q[0]), ALIGN_LSB)
                    && low_clear(BUS_W'(word_q[1]), ALIGN_LSB);
    assign start_req = bus_wr && dec.hit && (dec.sel == SEL_RUN)  &&  bus_wdata[0];
    assign clr_req   = bus_wr && dec.hit && (dec.sel == SEL_DONE) && !bus_wdata[0];

    dmar_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .start_ok  (aligned),
        .clr_req   (clr_req),
        .eng_done  (eng_done),
        .running   (running),
        .done      (done_q)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_DST:  rd_mux = 64'(word_q[0]);
            SEL_LEN:  rd_mux = 64'(word_q[1]);
            SEL_RUN:  rd_mux = {63'd0, running};
            SEL_DONE: rd_mux = {63'd0, done_q};
            default:  rd_mux = '0;
        endcase
    end

    assign rd_hit = bus_rd && dec.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_hit;
            if (rd_hit) bus_rdata <= rd_mux;
        end
    end

    assign eng_dst_addr = word_q[0];
    assign eng_len      = word_q[1];
    assign eng_busy     = running;
    assign irq          = done_q;

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.hit) |=> bus_rvalid); // R10

    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_rd && dec.hit)); // R1

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(aligned)); // R5
endmodule

// File: tb/dma_ctrl_regs_tb.sv
`timescale 1ns/1ps
module dma_ctrl_regs_tb;
    localparam logic [63:0] BASE = 64'h1001_7000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic        bus_rvalid, eng_busy, irq;
    logic [63:0] bus_rdata, eng_dst_addr, eng_len;
    logic        eng_addr_upd = 1'b0, eng_len_upd = 1'b0, eng_done = 1'b0;
    logic [63:0] eng_addr_val = '0, eng_len_val = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [63:0] m_dst = '0, m_len = '0;
    bit          m_run = 1'b0, m_done = 1'b0;

    always #2 clk = ~clk;

    dma_ctrl_regs u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .eng_dst_addr(eng_dst_addr), .eng_len(eng_len), .eng_busy(eng_busy),
        .eng_addr_upd(eng_addr_upd), .eng_addr_val(eng_addr_val),
        .eng_len_upd(eng_len_upd), .eng_len_val(eng_len_val),
        .eng_done(eng_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input logic [5:0] off);
        case (off)
            6'h00:   return m_dst;
            6'h08:   return m_len;
            6'h10:   return {63'd0, m_run};
            6'h18:   return {63'd0, m_done};
            default: return 64'd0;
        endcase
    endfunction

    // One bus cycle: drive at a falling edge, check at the next falling edge.
    task automatic cyc(input bit wr, input bit rd, input logic [63:0] a, input logic [63:0] wd,
                       input bit ua_en, input logic [63:0] ua, input bit ul_en,
                       input logic [63:0] ul, input bit dn, input string tag);
        bit          hit, aligned;
        logic [5:0]  off;
        logic [63:0] exp_rd, n_dst, n_len;
        bit          n_run, n_done;
        hit     = (a[63:6] == BASE[63:6]);
        off     = a[5:0];
        exp_rd  = model_read(off);
        aligned = (m_dst[2:0] == 3'd0) && (m_len[2:0] == 3'd0);
        n_dst = m_dst; n_len = m_len; n_run = m_run; n_done = m_done;
        if (hit && wr && off == 6'h00) n_dst = wd;
        if (hit && wr && off == 6'h08) n_len = wd;
        if (m_run && ua_en) n_dst = ua;
        if (m_run && ul_en) n_len = ul;
        if (m_run && dn) begin
            n_run = 1'b0; n_done = 1'b1;
        end else begin
            if (!m_run && hit && wr && off == 6'h10 && wd[0] && aligned) n_run = 1'b1;
            if (hit && wr && off == 6'h18 && !wd[0]) n_done = 1'b0;
        end
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        eng_addr_upd = ua_en; eng_addr_val = ua;
        eng_len_upd = ul_en; eng_len_val = ul; eng_done = dn;
        @(negedge clk);
        chk(tag, {63'd0, bus_rvalid}, {63'd0, rd && hit});
        if (rd && hit) chk(tag, bus_rdata, exp_rd);
        chk("R8", {63'd0, irq}, {63'd0, n_done});
        chk("R4", {63'd0, eng_busy}, {63'd0, n_run});
        chk("R2", eng_dst_addr, n_dst);
        chk("R3", eng_len, n_len);
        m_dst = n_dst; m_len = n_len; m_run = n_run; m_done = n_done;
        bus_wr = 1'b0; bus_rd = 1'b0; eng_addr_upd = 1'b0; eng_len_upd = 1'b0; eng_done = 1'b0;
    endtask

    task automatic wr_reg(input logic [5:0] off, input logic [63:0] wd);
        cyc(1'b1, 1'b0, BASE | 64'(off), wd, 1'b0, '0, 1'b0, '0, 1'b0, "R10");
    endtask

    task automatic rd_reg(input logic [5:0] off, input string tag);
        cyc(1'b0, 1'b1, BASE | 64'(off), '0, 1'b0, '0, 1'b0, '0, 1'b0, tag);
    endtask

    initial begin
        #(4ns * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        rd_reg(6'h00, "R11"); rd_reg(6'h08, "R11");
        rd_reg(6'h10, "R11"); rd_reg(6'h18, "R11");
        chk("R11", {63'd0, irq}, 64'd0);
        // R1: outside the window
        cyc(1'b1, 1'b0, BASE ^ 64'h1000, 64'hdead_beef, 1'b0, '0, 1'b0, '0, 1'b0, "R1");
        rd_reg(6'h00, "R1");
        cyc(1'b0, 1'b1, BASE ^ 64'h40, '0, 1'b0, '0, 1'b0, '0, 1'b0, "R1");
        // R2 / R3 full-width access
        wr_reg(6'h00, 64'hfedc_ba98_7654_3210); rd_reg(6'h00, "R2");
        wr_reg(6'h08, 64'h8000_0000_0000_0020); rd_reg(6'h08, "R3");
        // R10: unused offsets
        wr_reg(6'h20, '1); rd_reg(6'h20, "R10"); rd_reg(6'h0c, "R10");
        // R5: misaligned start refused
        wr_reg(6'h00, 64'h8000_1043); wr_reg(6'h10, 64'd1); rd_reg(6'h10, "R5");
        wr_reg(6'h00, 64'h8000_1040); wr_reg(6'h08, 64'h24);
        wr_reg(6'h10, 64'd1); rd_reg(6'h10, "R5");
        wr_reg(6'h08, 64'h20);
        // R4: aligned start, zero write ignored
        wr_reg(6'h10, 64'd0); rd_reg(6'h10, "R4");
        wr_reg(6'h10, 64'd1); rd_reg(6'h10, "R4");
        // R9: engine beats bus
        cyc(1'b1, 1'b0, BASE, 64'h1111_0000, 1'b1, 64'h8000_1048, 1'b1, 64'h18, 1'b0, "R9");
        rd_reg(6'h00, "R9"); rd_reg(6'h08, "R9");
        // R6: end of transfer
        cyc(1'b0, 1'b0, BASE, '0, 1'b0, '0, 1'b0, '0, 1'b1, "R6");
        rd_reg(6'h10, "R6"); rd_reg(6'h18, "R6");
        // R9: engine update ignored while idle
        cyc(1'b0, 1'b0, BASE, '0, 1'b1, 64'h55, 1'b1, 64'h66, 1'b0, "R9");
        rd_reg(6'h00, "R9"); rd_reg(6'h08, "R9");
        // R7: set beats clear in the same cycle
        wr_reg(6'h10, 64'd1);
        cyc(1'b1, 1'b0, BASE | 64'h18, 64'd0, 1'b0, '0, 1'b0, '0, 1'b1, "R7");
        rd_reg(6'h18, "R7");
        wr_reg(6'h18, 64'd1); rd_reg(6'h18, "R7");
        wr_reg(6'h18, 64'd0); rd_reg(6'h18, "R7");
        // R6: end pulse while idle ignored
        cyc(1'b0, 1'b0, BASE, '0, 1'b0, '0, 1'b0, '0, 1'b1, "R6");
        rd_reg(6'h18, "R6"); rd_reg(6'h10, "R6");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] a, wd, ua, ul;
            int k;
            k = $urandom % 10;
            case (k)
                0, 1:    a = BASE;
                2, 3:    a = BASE | 64'h08;
                4, 5:    a = BASE | 64'h10;
                6:       a = BASE | 64'h18;
                7, 8:    a = BASE | 64'($urandom % 64);
                default: a = BASE ^ (64'(1 + $urandom % 255) << 6);
            endcase
            wd = {$urandom, $urandom};
            if ($urandom % 4 != 0) wd[2:0] = 3'd0;
            if (a[5:0] == 6'h10 || a[5:0] == 6'h18) wd = 64'($urandom % 2);
            ua = {$urandom, $urandom} & ~64'h7;
            ul = {$urandom, $urandom} & ~64'h7;
            cyc(bit'($urandom % 2), bit'($urandom % 2), a, wd,
                bit'($urandom % 4 == 0), ua, bit'($urandom % 4 == 0), ul,
                m_run ? bit'($urandom % 8 == 0) : bit'($urandom % 16 == 0), "R10");
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule